// File: doc/BRIEF.md
# Cache Snoop Response Controller

This block is the snoop side of a write-back on-chip cache that shares a processor bus with another master. The other master requests the bus with a hold request and gets a hold acknowledge back. It then presents a snoop address with a strobe and an invalidate qualifier. The block looks the address up in a small direct-mapped line store, where each 16-byte line has a tag, a valid bit and a modified bit. It reports a hit to a modified line on an active-low output. That output is valid in the second clock after the strobe.

A hit to a modified line starts a deferred write-back. The controller waits until the other master drops its hold request. It then writes the line out as a four-beat burst of 32-bit words, starting at line offset zero, and each beat completes on a ready input. Further snoop strobes are ignored until the burst has completed. The line store can be preloaded through a test port, and the same port reads back the state of the addressed line.

Top module: `snoop_resp_ctrl`

## Requirements
- R1: `hold_ack_o` follows `hold_req_i` one clock later. While a write-back burst is running, the acknowledge stays low even if the request is high, and it rises one clock after the burst ends.
- R2: A strobe is accepted only when `hold_ack_o` was high in the cycle of the strobe and in the cycle before it. A strobe that is not accepted has no effect: `hitm_no` stays high, no write-back starts and the line state is unchanged.
- R3: For an accepted snoop, `hitm_no` is still high in the cycle after the strobe and takes its result in the second cycle after the strobe. A hit to a modified line drives it low.
- R4: On a snoop miss (the line is invalid, or its tag differs), `hitm_no` is high and the line state is unchanged, whatever the value of `snp_inv_i`.
- R5: On a hit to a valid line that is not modified, `hitm_no` is high.
- R6: On a hit to a clean line with `snp_inv_i`=1 the line becomes invalid. With `snp_inv_i`=0 it stays valid.
- R7: After a modified hit, `wb_req_o` stays low while `hold_req_i` is high. The burst starts in the clock after `hold_req_i` is seen low.
- R8: The burst has exactly four beats. Beat k carries address {tag, index, k, 2'b00}, that is n, n+4, n+8, n+12 with offset 0 first, and carries word k of the line. `wb_last_o` is high only on beat 3. A beat advances only on a clock where `wb_rdy_i` is high, so wait states keep the address and data stable.
- R9: Strobes that arrive between a modified hit and the end of its write-back are ignored, even when the acknowledge is high.
- R10: When the last beat is accepted, `hitm_no` returns high. The line becomes invalid if the snoop had `snp_inv_i`=1. If it had `snp_inv_i`=0, the line becomes valid and not modified.
- R11: After reset, `hold_ack_o`=0, `hitm_no`=1, `wb_req_o`=0, and every line is invalid and not modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_req_i | input | 1 | Bus hold request from the other master |
| hold_ack_o | output | 1 | Hold acknowledge |
| snp_strobe_i | input | 1 | Snoop address strobe, active high |
| snp_inv_i | input | 1 | Snoop qualifier: 1 = caused by a write (invalidate), 0 = caused by a read |
| snp_addr_i | input | ADDR_W | Snoop byte address |
| hitm_no | output | 1 | Hit to a modified line, active low |
| wb_req_o | output | 1 | Write-back beat is being presented |
| wb_addr_o | output | ADDR_W | Write-back beat address |
| wb_data_o | output | DATA_W | Write-back beat data |
| wb_last_o | output | 1 | Final beat of the burst |
| wb_rdy_i | input | 1 | Beat accepted by memory |
| pl_we_i | input | 1 | Test port: write the tag and state of line pl_idx_i |
| pl_idx_i | input | IDX_W | Test port line index (writes and read-back) |
| pl_tag_i | input | TAG_W | Test port tag |
| pl_valid_i | input | 1 | Test port valid bit |
| pl_dirty_i | input | 1 | Test port modified bit |
| pl_dwe_i | input | 1 | Test port: write one data word |
| pl_word_i | input | BEAT_W | Test port word index within the line |
| pl_wdata_i | input | DATA_W | Test port data word |
| tst_valid_o | output | 1 | Valid bit of line pl_idx_i |
| tst_dirty_o | output | 1 | Modified bit of line pl_idx_i |

## Verification
Snoops are driven against three preloaded line conditions: an absent or tag-mismatched line, a clean valid line and a modified line. Each is tried with both qualifier values. This separates the indication from the state update: misses and clean hits must look the same at `hitm_no`, and the test port must show that only the clean hit with the qualifier set invalidates the line. Modified hits are run with and without wait states and with the hold request raised again during the burst, which separates beat pacing from hold arbitration. Strobes issued too early after the acknowledge, and strobes issued during a pending write-back, must leave a second modified line untouched.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    WB_IDLE,
    WB_WAIT,
    WB_BURST
  } wb_state_e;

  typedef struct packed {
    logic valid;
    logic dirty;
  } line_st_t;
endpackage

// File: rtl/snp_line_store.sv
module snp_line_store
  import snp_pkg::*;
#(
  parameter int TAG_W  = 24,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int BEATS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic [TAG_W-1:0]  lk_tag_o,
  output line_st_t          lk_st_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [BEAT_W-1:0] rd_beat_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  line_st_t          upd_st_i,
  input  logic              pl_we_i,
  input  logic [IDX_W-1:0]  pl_idx_i,
  input  logic [TAG_W-1:0]  pl_tag_i,
  input  line_st_t          pl_st_i,
  input  logic              pl_dwe_i,
  input  logic [BEAT_W-1:0] pl_word_i,
  input  logic [DATA_W-1:0] pl_wdata_i,
  output line_st_t          tst_st_o
);
  logic [TAG_W-1:0]  tag_q  [LINES];
  line_st_t          st_q   [LINES];
  logic [DATA_W-1:0] data_q [LINES][BEATS];

  // controller updates win over the test port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= '0;
    end else if (upd_en_i) begin
      st_q[upd_idx_i] <= upd_st_i;
    end else if (pl_we_i) begin
      st_q[pl_idx_i] <= pl_st_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (pl_we_i) tag_q[pl_idx_i] <= pl_tag_i;
  end

  always_ff @(posedge clk_i) begin
    if (pl_dwe_i) data_q[pl_idx_i][pl_word_i] <= pl_wdata_i;
  end

  assign lk_tag_o  = tag_q[lk_idx_i];
  assign lk_st_o   = st_q[lk_idx_i];
  assign rd_data_o = data_q[rd_idx_i][rd_beat_i];
  assign tst_st_o  = st_q[pl_idx_i];
endmodule

// File: rtl/snp_wb_seq.sv
module snp_wb_seq
  import snp_pkg::*;
#(
  parameter int TAG_W  = 24,
  parameter int IDX_W  = 4,
  parameter int BEATS  = 4,
  parameter int DATA_W = 32,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int ADDR_W = TAG_W + IDX_W + BEAT_W + BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  input  logic [TAG_W-1:0]  start_tag_i,
  input  logic              start_inv_i,
  input  logic              hold_req_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              burst_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  line_idx_o,
  output logic              line_inv_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              wb_last_o
);
  wb_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic              inv_q;
  logic [BEAT_W-1:0] beat_q;
  logic              last_beat;

  assign last_beat = (beat_q == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WB_IDLE;
      idx_q   <= '0;
      tag_q   <= '0;
      inv_q   <= 1'b0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        WB_IDLE: if (start_i) begin
          state_q <= WB_WAIT;
          idx_q   <= start_idx_i;
          tag_q   <= start_tag_i;
          inv_q   <= start_inv_i;
        end
        // bus stays with the other master until it drops hold
        WB_WAIT: if (!hold_req_i) begin
          state_q <= WB_BURST;
          beat_q  <= '0;
        end
        WB_BURST: if (rdy_i) begin
          if (last_beat) state_q <= WB_IDLE;
          else           beat_q  <= beat_q + 1'b1;
        end
        default: state_q <= WB_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != WB_IDLE);
  assign burst_o    = (state_q == WB_BURST);
  assign done_o     = burst_o && rdy_i && last_beat;
  assign line_idx_o = idx_q;
  assign line_inv_o = inv_q;
  assign beat_o     = beat_q;
  assign wb_addr_o  = {tag_q, idx_q, beat_q, {BYTE_W{1'b0}}};
  assign wb_data_o  = rd_data_i;
  assign wb_last_o  = burst_o && last_beat;
endmodule

// File: rtl/snoop_resp_ctrl.sv
module snoop_resp_ctrl
  import snp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int BEATS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int BEAT_W = $clog2(BEATS),
  localparam int OFF_W  = BEAT_W + $clog2(DATA_W / 8),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_req_i,
  output logic              hold_ack_o,
  input  logic              snp_strobe_i,
  input  logic              snp_inv_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              hitm_no,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              wb_last_o,
  input  logic              wb_rdy_i,
  input  logic              pl_we_i,
  input  logic [IDX_W-1:0]  pl_idx_i,
  input  logic [TAG_W-1:0]  pl_tag_i,
  input  logic              pl_valid_i,
  input  logic              pl_dirty_i,
  input  logic              pl_dwe_i,
  input  logic [BEAT_W-1:0] pl_word_i,
  input  logic [DATA_W-1:0] pl_wdata_i,
  output logic              tst_valid_o,
  output logic              tst_dirty_o
);
  logic              ack_q, ack_prev_q, hitm_q;
  logic              s1_vld_q, s1_inv_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  line_st_t          lk_st, upd_st, tst_st;
  logic              hit, dirty_hit, clean_inv, accept, upd_en;
  logic [IDX_W-1:0]  upd_idx, rd_idx;
  logic [BEAT_W-1:0] rd_beat;
  logic [DATA_W-1:0] rd_data;
  logic              wb_busy, wb_burst, wb_done, wb_inv;
  logic [IDX_W-1:0]  wb_idx;

  assign lk_idx    = s1_addr_q[OFF_W +: IDX_W];
  assign hit       = s1_vld_q && lk_st.valid && (lk_tag == s1_addr_q[ADDR_W-1 -: TAG_W]);
  assign dirty_hit = hit && lk_st.dirty;
  assign clean_inv = hit && !lk_st.dirty && s1_inv_q;
  // acknowledge must have been up for a full clock before the strobe counts
  assign accept    = snp_strobe_i && ack_q && ack_prev_q && !wb_busy && !dirty_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q      <= 1'b0;
      ack_prev_q <= 1'b0;
      hitm_q     <= 1'b1;
      s1_vld_q   <= 1'b0;
      s1_inv_q   <= 1'b0;
      s1_addr_q  <= '0;
    end else begin
      ack_q      <= hold_req_i && (ack_q || !wb_burst);
      ack_prev_q <= ack_q;
      s1_vld_q   <= accept;
      if (accept) begin
        s1_inv_q  <= snp_inv_i;
        s1_addr_q <= snp_addr_i;
      end
      if (dirty_hit)    hitm_q <= 1'b0;
      else if (wb_done) hitm_q <= 1'b1;
    end
  end

  assign upd_en  = wb_done || clean_inv;
  assign upd_idx = wb_done ? wb_idx : lk_idx;
  assign upd_st  = wb_done ? '{valid: !wb_inv, dirty: 1'b0} : '0;

  snp_line_store #(
    .TAG_W (TAG_W),
    .DATA_W(DATA_W),
    .LINES (LINES),
    .BEATS (BEATS)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_idx_i  (lk_idx),
    .lk_tag_o  (lk_tag),
    .lk_st_o   (lk_st),
    .rd_idx_i  (rd_idx),
    .rd_beat_i (rd_beat),
    .rd_data_o (rd_data),
    .upd_en_i  (upd_en),
    .upd_idx_i (upd_idx),
    .upd_st_i  (upd_st),
    .pl_we_i   (pl_we_i),
    .pl_idx_i  (pl_idx_i),
    .pl_tag_i  (pl_tag_i),
    .pl_st_i   ('{valid: pl_valid_i, dirty: pl_dirty_i}),
    .pl_dwe_i  (pl_dwe_i),
    .pl_word_i (pl_word_i),
    .pl_wdata_i(pl_wdata_i),
    .tst_st_o  (tst_st)
  );

  snp_wb_seq #(
    .TAG_W (TAG_W),
    .IDX_W (IDX_W),
    .BEATS (BEATS),
    .DATA_W(DATA_W)
  ) u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (dirty_hit),
    .start_idx_i(lk_idx),
    .start_tag_i(lk_tag),
    .start_inv_i(s1_inv_q),
    .hold_req_i (hold_req_i),
    .rdy_i      (wb_rdy_i),
    .rd_data_i  (rd_data),
    .busy_o     (wb_busy),
    .burst_o    (wb_burst),
    .done_o     (wb_done),
    .line_idx_o (wb_idx),
    .line_inv_o (wb_inv),
    .beat_o     (rd_beat),
    .wb_addr_o  (wb_addr_o),
    .wb_data_o  (wb_data_o),
    .wb_last_o  (wb_last_o)
  );

  assign rd_idx      = wb_idx;
  assign hold_ack_o  = ack_q;
  assign hitm_no     = hitm_q;
  assign wb_req_o    = wb_burst;
  assign tst_valid_o = tst_st.valid;
  assign tst_dirty_o = tst_st.dirty;
endmodule

// File: rtl/snp_chk.sv
module snp_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int OFF_W = $clog2(BEATS) + $clog2(DATA_W / 8)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_req_i,
  input logic              hold_ack_o,
  input logic              hitm_no,
  input logic              wb_req_o,
  input logic [ADDR_W-1:0] wb_addr_o,
  input logic              wb_last_o,
  input logic              wb_rdy_i
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  // R1
  ack_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_ack_o) |-> $past(hold_req_i));
  // R7
  no_burst_under_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> !hold_ack_o);
  // R8
  first_beat_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_req_o) |-> (wb_addr_o[OFF_W-1:0] == '0));
  // R8
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && wb_rdy_i && !wb_last_o) |=> (wb_req_o && wb_addr_o == $past(wb_addr_o) + STEP));
  // R8
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && !wb_rdy_i) |=> (wb_req_o && $stable(wb_addr_o)));
  // R8
  last_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_last_o |-> wb_req_o);
  // R3
  hitm_during_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> !hitm_no);
  // R10
  hitm_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && wb_last_o && wb_rdy_i) |=> (hitm_no && !wb_req_o));
endmodule

bind snoop_resp_ctrl snp_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .BEATS (BEATS)
) u_chk (.*);

// File: tb/sim_snoop_resp_ctrl.sv
module sim_snoop_resp_ctrl;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LINES  = 16;
  localparam int BEATS  = 4;
  localparam int IDX_W  = 4;
  localparam int BEAT_W = 2;
  localparam int TAG_W  = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hold_req = 0, hold_ack, strobe = 0, inv = 0, hitm_n;
  logic [ADDR_W-1:0] addr = '0, wb_addr;
  logic [DATA_W-1:0] wb_data, pl_wdata = '0;
  logic wb_req, wb_last, wb_rdy = 0;
  logic pl_we = 0, pl_valid = 0, pl_dirty = 0, pl_dwe = 0;
  logic [IDX_W-1:0] pl_idx = '0;
  logic [TAG_W-1:0] pl_tag = '0;
  logic [BEAT_W-1:0] pl_word = '0;
  logic tst_valid, tst_dirty;
  int checks = 0, failures = 0;

  always #(CLK_P / 2) clk = ~clk;

  snoop_resp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .BEATS(BEATS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hold_req_i(hold_req), .hold_ack_o(hold_ack),
    .snp_strobe_i(strobe), .snp_inv_i(inv), .snp_addr_i(addr), .hitm_no(hitm_n),
    .wb_req_o(wb_req), .wb_addr_o(wb_addr), .wb_data_o(wb_data), .wb_last_o(wb_last),
    .wb_rdy_i(wb_rdy), .pl_we_i(pl_we), .pl_idx_i(pl_idx), .pl_tag_i(pl_tag),
    .pl_valid_i(pl_valid), .pl_dirty_i(pl_dirty), .pl_dwe_i(pl_dwe), .pl_word_i(pl_word),
    .pl_wdata_i(pl_wdata), .tst_valid_o(tst_valid), .tst_dirty_o(tst_dirty)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input logic [TAG_W-1:0] t, input int idx);
    return {t, IDX_W'(idx), 4'h0};
  endfunction

  function automatic logic [DATA_W-1:0] dpat(input int idx, input int w);
    return 32'hC0DE_0000 | DATA_W'(idx << 4) | DATA_W'(w);
  endfunction

  task automatic preload(input int idx, input logic [TAG_W-1:0] t, input logic v, input logic d);
    pl_idx = IDX_W'(idx); pl_tag = t; pl_valid = v; pl_dirty = d; pl_we = 1;
    step(); pl_we = 0;
    for (int w = 0; w < BEATS; w++) begin
      pl_word = BEAT_W'(w); pl_wdata = dpat(idx, w); pl_dwe = 1;
      step();
    end
    pl_dwe = 0;
  endtask

  task automatic line_st(input string req, input int idx, input logic v, input logic d);
    pl_idx = IDX_W'(idx); #1;
    chk({req, " valid"}, tst_valid, v);
    chk({req, " dirty"}, tst_dirty, d);
  endtask

  task automatic grant();
    hold_req = 1; step(); step();
  endtask

  task automatic release_hold();
    hold_req = 0; step(); step();
  endtask

  // strobe one cycle, check hitm stays high in cycle 1 and takes exp in cycle 2
  task automatic snoop(input string req, input logic [ADDR_W-1:0] a, input logic iv, input logic exp);
    addr = a; inv = iv; strobe = 1;
    step(); strobe = 0;
    chk({req, " hitm cycle1"}, hitm_n, 1'b1);
    step();
    chk({req, " hitm cycle2"}, hitm_n, exp);
  endtask

  task automatic t_reset();
    chk("R11 ack", hold_ack, 0);
    chk("R11 hitm", hitm_n, 1);
    chk("R11 wb_req", wb_req, 0);
    line_st("R11 line5", 5, 0, 0);
  endtask

  task automatic t_ack();
    hold_req = 1; #1;
    chk("R1 ack before edge", hold_ack, 0);
    step();
    chk("R1 ack one clock after req", hold_ack, 1);
    hold_req = 0; step();
    chk("R1 ack drops", hold_ack, 0);
  endtask

  task automatic t_early();
    preload(2, 24'hABCDE1, 1, 1);
    // strobe without any acknowledge
    snoop("R2 no ack", mk_addr(24'hABCDE1, 2), 0, 1);
    // strobe in the first acknowledged cycle
    hold_req = 1; step();
    snoop("R2 early strobe", mk_addr(24'hABCDE1, 2), 1, 1);
    step();
    chk("R2 no burst", wb_req, 0);
    line_st("R2 line2", 2, 1, 1);
    release_hold();
  endtask

  task automatic t_miss();
    preload(3, 24'h111111, 1, 0);
    grant();
    snoop("R4 tag miss inv1", mk_addr(24'h222222, 3), 1, 1);
    line_st("R4 tag miss keeps line", 3, 1, 0);
    snoop("R4 invalid line inv0", mk_addr(24'h333333, 7), 0, 1);
    line_st("R4 invalid line stays", 7, 0, 0);
    release_hold();
  endtask

  task automatic t_clean();
    preload(4, 24'h444444, 1, 0);
    grant();
    snoop("R5 clean hit inv0", mk_addr(24'h444444, 4), 0, 1);
    line_st("R6 read snoop keeps", 4, 1, 0);
    snoop("R5 clean hit inv1", mk_addr(24'h444444, 4), 1, 1);
    line_st("R6 write snoop invalidates", 4, 0, 0);
    release_hold();
  endtask

  task automatic t_dirty(input int idx, input logic [TAG_W-1:0] t, input logic iv,
                         input bit waits, input bit rehold);
    int other;
    other = idx + 1;
    preload(idx, t, 1, 1);
    preload(other, t, 1, 1);
    grant();
    snoop("R3 dirty hit", mk_addr(t, idx), iv, 0);
    // R9: strobe the other modified line while the write-back is pending
    addr = mk_addr(t, other); inv = 1; strobe = 1;
    step(); strobe = 0;
    chk("R7 wait for hold drop", wb_req, 0);
    step();
    chk("R7 still waiting", wb_req, 0);
    chk("R3 hitm held low", hitm_n, 0);
    hold_req = 0; step();
    chk("R7 burst starts", wb_req, 1);
    if (rehold) hold_req = 1;
    for (int b = 0; b < BEATS; b++) begin
      chk("R8 addr", wb_addr, mk_addr(t, idx) + ADDR_W'(4 * b));
      chk("R8 data", wb_data, dpat(idx, b));
      chk("R8 last", wb_last, b == BEATS - 1);
      if (rehold) chk("R1 ack held off in burst", hold_ack, 0);
      if (waits) begin
        wb_rdy = 0; step();
        chk("R8 wait keeps addr", wb_addr, mk_addr(t, idx) + ADDR_W'(4 * b));
        chk("R8 wait keeps req", wb_req, 1);
      end
      wb_rdy = 1; step();
    end
    wb_rdy = 0;
    chk("R10 burst ended", wb_req, 0);
    chk("R10 hitm released", hitm_n, 1);
    if (rehold) begin
      chk("R1 ack still low at end", hold_ack, 0);
      step();
      chk("R1 ack after burst", hold_ack, 1);
      hold_req = 0;
    end
    step(); step();
    chk("R9 no second burst", wb_req, 0);
    chk("R9 hitm stays high", hitm_n, 1);
    line_st("R10 line after write-back", idx, !iv, 0);
    line_st("R9 ignored line untouched", other, 1, 1);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_ack();
    t_early();
    t_miss();
    t_clean();
    t_dirty(8, 24'h5A5A01, 0, 1, 0);
    t_dirty(10, 24'h0F0F02, 1, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule